// File: doc/BRIEF.md
# Bit-Field Barrel Shifter

This block is the shifting unit of a processing element's datapath. Each accepted operation reads three 32-bit words: an X word holding the data, a Y word holding the control value, and a Z word that some operations merge into the result. It computes one of fourteen operations: shifts and rotates by a signed amount, single-bit set/clear/toggle/test, bit-field deposit and extract, merging variants, leading-bit counts and an exponent extract. It produces a 32-bit result and three flags.

The result and the flags are registered. An operation presented with `in_valid` high appears on the outputs one clock later, with `out_valid` high in that cycle. A new operation may be issued on every cycle. When no operation is issued, the outputs hold their last values. Bit test produces a condition and no data, so the result register is left untouched.

Top module: `bfield_shifter`

## Requirements
- R1: While `rst_n` is low, and after its release until the first accepted operation, `out_valid`, `result` and all three flags are 0.
- R2: An operation accepted with `in_valid` high is reflected on the outputs on the next clock edge, and `out_valid` is high for exactly that cycle. A cycle with `in_valid` low changes no output except that `out_valid` goes low.
- R3: Shift ops use the signed amount n = `y_in[7:0]`. Op 0 is a logical shift and op 1 is an arithmetic shift. A positive n shifts left, filling with zeros. A negative n shifts right by -n: op 0 fills with zeros and op 1 fills with copies of bit 31. A magnitude of 32 or more gives all zeros, except for an arithmetic right shift, which gives 32 copies of bit 31.
- R4: For ops 0, 1 and 9, `ovf_flag` is 1 exactly when a left shift moves at least one 1 bit past bit 31. Right shifts clear it.
- R5: Op 2 rotates left by `y_in[4:0]`, which is the same as rotating by n modulo 32, so a negative n rotates right. Op 2 always clears `ovf_flag`.
- R6: Op 3 sets, op 4 clears and op 5 inverts bit `y_in[4:0]` of X, and each returns the modified word. These ops clear `ovf_flag`.
- R7: Op 6 (bit test) sets `zero_flag` to 1 when bit `y_in[4:0]` of X is 0, and to 0 otherwise. It leaves `result`, `ovf_flag` and `xsign_flag` unchanged.
- R8: Op 7 (deposit) takes position p = `y_in[5:0]` and length L = `y_in[11:6]`, with any L above 32 treated as 32. It places the L low bits of X at bits p upward and fills every other bit with 0. Field bits that would land above bit 31 are dropped, and `ovf_flag` is 1 exactly when one of the dropped bits is a 1.
- R9: Op 8 (extract) returns L bits of X starting at bit p, right-aligned, with the upper bits zero. Source positions above bit 31 read as 0, L = 0 gives 0, and `ovf_flag` is cleared.
- R10: When `sext` is 1 and L is nonzero, ops 7, 8 and 10 replicate the top bit of the field into every result bit above the field. Deposit overflow still counts only the field bits.
- R11: Op 9 returns Z OR (the op 0 result), and op 10 returns Z OR (the op 7 result). Each takes its overflow from the underlying operation.
- R12: Op 11 returns the number of leading 0 bits of X and op 12 returns the number of leading 1 bits, each from 0 to 32. Both clear `ovf_flag`.
- R13: Op 13 returns 1 minus the number of leading bits of X equal to bit 31, as a 32-bit two's-complement value. It clears `ovf_flag` and loads `xsign_flag` with X bit 31. No other op changes `xsign_flag`.
- R14: For every op from 0 to 13 other than op 6, `zero_flag` is 1 exactly when the new `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code (0 to 13) |
| sext | input | 1 | Sign-extend the field for deposit/extract ops |
| x_in | input | 32 | Data operand |
| y_in | input | 32 | Shift amount, bit index, or field position and length |
| z_in | input | 32 | Merge operand for ops 9 and 10 |
| out_valid | output | 1 | Result of an operation is present |
| result | output | 32 | Registered result |
| zero_flag | output | 1 | Result zero, or tested bit clear |
| ovf_flag | output | 1 | Set bits lost past bit 31 |
| xsign_flag | output | 1 | X sign captured by the exponent extract |

## Verification
The result and the three flags sit in one state register. A fault in the next-state selection therefore shows up on the ports in the very next cycle. Examples are a flag updated by the wrong operation, or a result overwritten by a bit test. Faults that corrupt held state show up during idle cycles and after a bit test, because the bench compares the held values against the last result it expects. Because flags persist across operations, a sign flag that is disturbed wrongly stays visible until the next exponent extract. The stimulus therefore interleaves that operation with all the others.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

    typedef enum logic [3:0] {
        OP_LSH     = 4'd0,
        OP_ASH     = 4'd1,
        OP_ROT     = 4'd2,
        OP_BSET    = 4'd3,
        OP_BCLR    = 4'd4,
        OP_BTGL    = 4'd5,
        OP_BTST    = 4'd6,
        OP_FDEP    = 4'd7,
        OP_FEXT    = 4'd8,
        OP_LSH_OR  = 4'd9,
        OP_FDEP_OR = 4'd10,
        OP_CLZ     = 4'd11,
        OP_CLO     = 4'd12,
        OP_EXPX    = 4'd13
    } shf_op_e;

    typedef enum logic [1:0] {
        SH_LOG = 2'd0,
        SH_ARI = 2'd1,
        SH_ROT = 2'd2
    } shmode_e;

endpackage

// File: rtl/shf_barrel.sv
module shf_barrel
    import bfs_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 8
) (
    input  logic [W-1:0]  x,
    input  logic [AW-1:0] amt,
    input  shmode_e       mode,
    output logic [W-1:0]  res,
    output logic          ovf
);
    localparam int SW = $clog2(W);
    localparam logic [AW-1:0] WLIM = AW'(W);

    logic          neg;
    logic [AW-1:0] mag;
    logic          big;
    logic [2*W-1:0] wide;
    logic [2*W-1:0] rot2;

    always_comb begin
        neg  = amt[AW-1];
        mag  = neg ? (~amt + AW'(1)) : amt;
        big  = (mag >= WLIM);
        wide = {{W{1'b0}}, x} << mag[SW-1:0];
        rot2 = {x, x} << amt[SW-1:0];
        res  = '0;
        ovf  = 1'b0;
        if (mode == SH_ROT) begin
            res = rot2[2*W-1:W];
        end else if (!neg) begin
            if (big) begin
                res = '0;
                ovf = |x;
            end else begin
                res = wide[W-1:0];
                ovf = |wide[2*W-1:W];
            end
        end else begin
            if (big) begin
                res = (mode == SH_ARI) ? {W{x[W-1]}} : '0;
            end else if (mode == SH_ARI) begin
                res = $signed(x) >>> mag[SW-1:0];
            end else begin
                res = x >> mag[SW-1:0];
            end
        end
    end

endmodule

// File: rtl/shf_field.sv
module shf_field #(
    parameter int W  = 32,
    parameter int PW = 6
) (
    input  logic [W-1:0]  x,
    input  logic [PW-1:0] pos,
    input  logic [PW-1:0] len,
    input  logic          sext,
    input  logic          extract,
    output logic [W-1:0]  res,
    output logic          ovf
);
    localparam int SW = $clog2(W);
    localparam logic [PW-1:0] WL = PW'(W);

    logic [PW-1:0]  leff;
    logic [PW-1:0]  mi;
    logic [W-1:0]   mask;
    logic [W-1:0]   fld;
    logic [W-1:0]   ext;
    logic [W-1:0]   sh;
    logic           msb;
    logic           ext_on;
    logic [2*W-1:0] wfill;
    logic [2*W-1:0] wplain;

    assign leff = (len > WL) ? WL : len;
    assign mi   = leff - PW'(1);

    for (genvar i = 0; i < W; i++) begin : g_mask
        assign mask[i] = (PW'(i) < leff);
    end

    always_comb begin
        sh     = (pos >= WL) ? '0 : (x >> pos);
        msb    = extract ? sh[mi[SW-1:0]] : x[mi[SW-1:0]];
        ext_on = sext && (leff != '0) && msb;
        ext    = ext_on ? ~mask : '0;
        fld    = (extract ? sh : x) & mask;
        wfill  = {{W{ext_on}}, fld | ext} << pos[SW-1:0];
        wplain = {{W{1'b0}}, fld} << pos[SW-1:0];
        if (extract) begin
            res = fld | ext;
            ovf = 1'b0;
        end else if (pos >= WL) begin
            res = '0;
            ovf = |fld;
        end else begin
            res = wfill[W-1:0];
            ovf = |wplain[2*W-1:W];
        end
    end

endmodule

// File: rtl/shf_count.sv
module shf_count #(
    parameter int W  = 32,
    parameter int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  x,
    output logic [CW-1:0] lz,
    output logic [CW-1:0] lo,
    output logic [W-1:0]  expo
);
    logic          seen_z;
    logic          seen_o;
    logic [CW-1:0] ls;

    always_comb begin
        lz     = '0;
        lo     = '0;
        seen_z = 1'b0;
        seen_o = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!seen_z) begin
                if (!x[i]) lz = lz + CW'(1);
                else       seen_z = 1'b1;
            end
            if (!seen_o) begin
                if (x[i]) lo = lo + CW'(1);
                else      seen_o = 1'b1;
            end
        end
        ls   = x[W-1] ? lo : lz;
        expo = W'(1) - W'(ls);
    end

endmodule

// File: rtl/bfield_shifter.sv
module bfield_shifter
    import bfs_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 8,
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    op,
    input  logic          sext,
    input  logic [W-1:0]  x_in,
    input  logic [W-1:0]  y_in,
    input  logic [W-1:0]  z_in,
    output logic          out_valid,
    output logic [W-1:0]  result,
    output logic          zero_flag,
    output logic          ovf_flag,
    output logic          xsign_flag
);
    localparam int IW = $clog2(W);
    localparam int CW = $clog2(W) + 1;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] res;
        logic         zf;
        logic         vf;
        logic         sf;
    } st_t;

    st_t st_d, st_q;

    shf_op_e       opc;
    shmode_e       bmode;
    logic [W-1:0]  bar_res;
    logic          bar_ovf;
    logic [W-1:0]  fld_res;
    logic          fld_ovf;
    logic [CW-1:0] cnt_lz;
    logic [CW-1:0] cnt_lo;
    logic [W-1:0]  cnt_exp;
    logic [W-1:0]  bitsel;
    logic          upd_z;

    assign opc    = shf_op_e'(op);
    assign bmode  = (opc == OP_ASH) ? SH_ARI : (opc == OP_ROT) ? SH_ROT : SH_LOG;
    assign bitsel = {{(W-1){1'b0}}, 1'b1} << y_in[IW-1:0];

    shf_barrel #(.W(W), .AW(AW)) u_barrel (
        .x    (x_in),
        .amt  (y_in[AW-1:0]),
        .mode (bmode),
        .res  (bar_res),
        .ovf  (bar_ovf)
    );

    shf_field #(.W(W), .PW(PW)) u_field (
        .x       (x_in),
        .pos     (y_in[PW-1:0]),
        .len     (y_in[2*PW-1:PW]),
        .sext    (sext),
        .extract (opc == OP_FEXT),
        .res     (fld_res),
        .ovf     (fld_ovf)
    );

    shf_count #(.W(W), .CW(CW)) u_count (
        .x    (x_in),
        .lz   (cnt_lz),
        .lo   (cnt_lo),
        .expo (cnt_exp)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        upd_z    = 1'b0;
        if (in_valid) begin
            upd_z = 1'b1;
            case (opc)
                OP_LSH, OP_ASH, OP_ROT: begin
                    st_d.res = bar_res;
                    st_d.vf  = bar_ovf;
                end
                OP_BSET: begin
                    st_d.res = x_in | bitsel;
                    st_d.vf  = 1'b0;
                end
                OP_BCLR: begin
                    st_d.res = x_in & ~bitsel;
                    st_d.vf  = 1'b0;
                end
                OP_BTGL: begin
                    st_d.res = x_in ^ bitsel;
                    st_d.vf  = 1'b0;
                end
                OP_BTST: begin
                    upd_z   = 1'b0;
                    st_d.zf = ((x_in & bitsel) == '0);
                end
                OP_FDEP, OP_FEXT: begin
                    st_d.res = fld_res;
                    st_d.vf  = fld_ovf;
                end
                OP_LSH_OR: begin
                    st_d.res = z_in | bar_res;
                    st_d.vf  = bar_ovf;
                end
                OP_FDEP_OR: begin
                    st_d.res = z_in | fld_res;
                    st_d.vf  = fld_ovf;
                end
                OP_CLZ: begin
                    st_d.res = W'(cnt_lz);
                    st_d.vf  = 1'b0;
                end
                OP_CLO: begin
                    st_d.res = W'(cnt_lo);
                    st_d.vf  = 1'b0;
                end
                OP_EXPX: begin
                    st_d.res = cnt_exp;
                    st_d.vf  = 1'b0;
                    st_d.sf  = x_in[W-1];
                end
                default: upd_z = 1'b0;
            endcase
            if (upd_z) st_d.zf = (st_d.res == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.vld;
    assign result     = st_q.res;
    assign zero_flag  = st_q.zf;
    assign ovf_flag   = st_q.vf;
    assign xsign_flag = st_q.sf;

endmodule

// File: rtl/bfs_chk.sv
module bfs_chk
    import bfs_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [3:0]   op,
    input logic         out_valid,
    input logic [W-1:0] result,
    input logic         zero_flag,
    input logic         ovf_flag,
    input logic         xsign_flag
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(zero_flag)
                       && $stable(ovf_flag) && $stable(xsign_flag)));

    assert_rot_no_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_ROT) |=> !ovf_flag);

    assert_bitop_no_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_BSET || op == OP_BCLR || op == OP_BTGL)) |=> !ovf_flag);

    assert_btst_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_BTST) |=> ($stable(result) && $stable(ovf_flag)
                                         && $stable(xsign_flag)));

    assert_count_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_CLZ || op == OP_CLO)) |=> (result <= W'(W)));

    assert_sign_only_exp_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != OP_EXPX) |=> $stable(xsign_flag));

    assert_zero_match_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != OP_BTST && op <= OP_EXPX) |=> (zero_flag == (result == '0)));

endmodule

bind bfield_shifter bfs_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op         (op),
    .out_valid  (out_valid),
    .result     (result),
    .zero_flag  (zero_flag),
    .ovf_flag   (ovf_flag),
    .xsign_flag (xsign_flag)
);

// File: tb/bfield_shifter_test.sv
`timescale 1ns/1ps
module bfield_shifter_test;

    typedef struct {
        logic [31:0] r;
        logic        z;
        logic        v;
        logic        s;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic        sext = 1'b0;
    logic [31:0] x_in = '0, y_in = '0, z_in = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        zero_flag, ovf_flag, xsign_flag;

    int n_chk = 0;
    int n_bad = 0;
    exp_t q[$];
    exp_t last;
    bit   have_last = 0;
    logic [31:0] m_r = '0;
    logic m_z = 0, m_v = 0, m_s = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #2.5 clk = ~clk;

    bfield_shifter uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .sext(sext),
        .x_in(x_in), .y_in(y_in), .z_in(z_in), .out_valid(out_valid),
        .result(result), .zero_flag(zero_flag), .ovf_flag(ovf_flag),
        .xsign_flag(xsign_flag)
    );

    function automatic string tag_of(input int o);
        case (o)
            0, 1: return "R3";
            2: return "R5";
            3, 4, 5: return "R6";
            6: return "R7";
            7: return "R8";
            8: return "R9";
            9, 10: return "R11";
            11, 12: return "R12";
            default: return "R13";
        endcase
    endfunction

    function automatic logic [31:0] m_shift(input int mode, input logic [31:0] x,
                                            input logic [7:0] a, output bit ov);
        logic [31:0] r = '0;
        int n = int'($signed(a));
        ov = 0;
        for (int i = 0; i < 32; i++) begin
            if (mode == 2) begin
                r[i] = x[((i - n) % 32 + 32) % 32];
            end else if (n >= 0) begin
                r[i] = (i - n >= 0) ? x[i - n] : 1'b0;
                if (x[i] && i + n > 31) ov = 1;
            end else begin
                r[i] = (i - n <= 31) ? x[i - n] : (mode == 1 ? x[31] : 1'b0);
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] m_field(input bit ext, input bit sx, input logic [31:0] x,
                                            input logic [31:0] y, output bit ov);
        logic [31:0] r = '0;
        int p = int'(y[5:0]);
        int l = int'(y[11:6]);
        logic fm;
        if (l > 32) l = 32;
        ov = 0;
        if (ext) begin
            fm = (l > 0 && l - 1 + p < 32) ? x[l - 1 + p] : 1'b0;
            for (int i = 0; i < 32; i++) begin
                if (i < l) r[i] = (i + p < 32) ? x[i + p] : 1'b0;
                else       r[i] = sx && l > 0 && fm;
            end
        end else begin
            fm = (l > 0) ? x[l - 1] : 1'b0;
            for (int k = 0; k < l; k++) if (x[k] && k + p > 31) ov = 1;
            for (int i = 0; i < 32; i++) begin
                int k = i - p;
                if (k >= 0 && k < l) r[i] = x[k];
                else if (k >= l)     r[i] = sx && l > 0 && fm;
            end
        end
        return r;
    endfunction

    function automatic int lead(input logic [31:0] x, input logic b);
        int c = 0;
        for (int i = 31; i >= 0; i--) begin
            if (x[i] != b) break;
            c++;
        end
        return c;
    endfunction

    task automatic apply(input int o, input bit sx, input logic [31:0] x,
                         input logic [31:0] y, input logic [31:0] z);
        exp_t e;
        bit ov;
        logic [31:0] r;
        logic [31:0] bs = 32'h1 << y[4:0];
        ov = 0;
        r  = m_r;
        case (o)
            0, 1, 2: r = m_shift(o, x, y[7:0], ov);
            3: r = x | bs;
            4: r = x & ~bs;
            5: r = x ^ bs;
            7: r = m_field(0, sx, x, y, ov);
            8: r = m_field(1, sx, x, y, ov);
            9: r = z | m_shift(0, x, y[7:0], ov);
            10: r = z | m_field(0, sx, x, y, ov);
            11: r = 32'(lead(x, 1'b0));
            12: r = 32'(lead(x, 1'b1));
            13: begin
                r = 32'(1 - lead(x, x[31]));
                m_s = x[31];
            end
            default: ;
        endcase
        if (o == 6) begin
            m_z = ((x & bs) == 0);
        end else begin
            m_r = r;
            m_v = ov;
            m_z = (r == 0);
        end
        e.r = m_r; e.z = m_z; e.v = m_v; e.s = m_s; e.tag = tag_of(o);
        @(negedge clk);
        in_valid = 1'b1; op = 4'(o); sext = sx; x_in = x; y_in = y; z_in = z;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            x_in = $urandom; y_in = $urandom; z_in = $urandom;
        end
    endtask

    task automatic compare(input exp_t e, input string tag);
        n_chk++;
        if (result !== e.r || zero_flag !== e.z || ovf_flag !== e.v || xsign_flag !== e.s) begin
            n_bad++;
            $display("FAIL %s: got r=%h z=%b v=%b s=%b, expected r=%h z=%b v=%b s=%b",
                     tag, result, zero_flag, ovf_flag, xsign_flag, e.r, e.z, e.v, e.s);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R2: unexpected out_valid, expected none");
                end else begin
                    last = q.pop_front();
                    have_last = 1;
                    compare(last, last.tag);
                end
            end else begin
                exp_t z0;
                z0.r = '0; z0.z = 0; z0.v = 0; z0.s = 0; z0.tag = "R1";
                if (have_last) compare(last, "R2");
                else           compare(z0, "R1");
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(3);                                   // R1 reset state held
        // R3 shifts
        apply(0, 0, 32'h1, 32'd4, 0);
        apply(0, 0, 32'h8000_0000, 32'hFF, 0);
        apply(1, 0, 32'h8000_0000, 32'hFC, 0);
        apply(1, 0, 32'h8000_0000, 32'd216, 0);    // -40
        apply(0, 0, 32'hFFFF_FFFF, 32'h80, 0);     // -128
        // R4 overflow
        apply(0, 0, 32'h1, 32'd40, 0);
        apply(0, 0, 32'h4000_0000, 32'd1, 0);
        apply(0, 0, 32'h4000_0000, 32'd2, 0);
        apply(1, 0, 32'hC000_0000, 32'd1, 0);
        // R5 rotate
        apply(2, 0, 32'h8000_0001, 32'd1, 0);
        apply(2, 0, 32'h8000_0001, 32'hFF, 0);
        apply(2, 0, 32'h8000_0001, 32'd33, 0);
        // R6 bit ops
        apply(3, 0, 32'h0, 32'd31, 0);
        apply(4, 0, 32'hFFFF_FFFF, 32'd0, 0);
        apply(5, 0, 32'h0000_00F0, 32'd4, 0);
        // R7 bit test preceded by an overflow so held state is visible
        apply(0, 0, 32'h3, 32'd31, 0);
        apply(6, 0, 32'h10, 32'd4, 0);
        apply(6, 0, 32'h10, 32'd3, 0);
        idle(2);
        // R8 deposit
        apply(7, 0, 32'hFF, 32'h210, 0);
        apply(7, 0, 32'hFF, (32'd8 << 6) | 32'd28, 0);
        apply(7, 0, 32'hFF, (32'd8 << 6) | 32'd40, 0);
        apply(7, 0, 32'hFFFF_FFFF, (32'd40 << 6) | 32'd0, 0);
        // R9 extract
        apply(8, 0, 32'h8788_0000, 32'h217, 0);
        apply(8, 0, 32'h8788_0000, (32'd0 << 6) | 32'd4, 0);
        apply(8, 0, 32'hF000_0000, (32'd8 << 6) | 32'd30, 0);
        // R10 sign extension
        apply(7, 1, 32'h80, (32'd8 << 6) | 32'd4, 0);
        apply(8, 1, 32'h8788_0000, (32'd8 << 6) | 32'd24, 0);
        apply(8, 1, 32'h8788_0000, (32'd8 << 6) | 32'd20, 0);
        // R11 merging
        apply(9, 0, 32'h1, 32'd4, 32'hF000_0000);
        apply(10, 0, 32'hF, (32'd4 << 6) | 32'd8, 32'h1);
        // R12 counts
        apply(11, 0, 32'h0, 0, 0);
        apply(11, 0, 32'h1, 0, 0);
        apply(12, 0, 32'hFFFF_FFFF, 0, 0);
        apply(12, 0, 32'hF000_0000, 0, 0);
        // R13 exponent and sign flag persistence
        apply(13, 0, 32'h1, 0, 0);
        apply(13, 0, 32'h8000_0000, 0, 0);
        apply(0, 0, 32'h1, 32'd1, 0);
        idle(2);
        // R14 mixed pseudo-random traffic
        for (int i = 0; i < 400; i++) begin
            int o;
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            o = int'(rng % 14);
            apply(o, rng[20], $urandom, (i % 3 == 0) ? {20'b0, rng[31:20]} : $urandom, $urandom);
            if (rng[7:5] == 3'b0) idle(1);
        end
        idle(4);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule